// File: doc/BRIEF.md
# Timer Edge Capture Unit

The unit sits beside a free-running timer counter and records when things happen on external pins. Each channel watches one asynchronous capture pin. The pin is first brought into the clock domain by a two-flop synchroniser. An edge is then found by comparing the synchronised level with a copy of it taken one clock later. When a selected edge is seen, the channel copies the current timer count into its own capture register. If the channel's interrupt enable is set, it also sets a sticky flag.

Each channel has three plain control inputs: capture on a rising edge, capture on a falling edge, and raise an interrupt on capture. The two edge selects are independent. Setting both captures on every transition, and clearing both stops the channel from loading. Software clears flags by a write-one-to-clear strobe. The capture registers can only be read, so they appear as output ports. The counter, the bus protocol and any prescaler are outside the block. Every pin is a level or pulse control signal; no data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `edge_capture_unit`

## Requirements
- R1: A rising transition on a capture pin, with that channel's rising select set, loads the timer count present at the third rising clock edge after the pin changes into that channel's capture register. The new value is visible right after that edge.
- R2: A falling transition, with the falling select set, loads the count with the same timing as R1. A transition whose direction is not selected leaves the register unchanged.
- R3: With both selects set, every transition in either direction loads the count.
- R4: With both selects clear, transitions leave the capture register and the flag unchanged.
- R5: A capture sets the channel's flag (bit c of `cap_flags` for channel c) only when that channel's interrupt enable is set. The register still loads when the enable is clear.
- R6: `irq` is high exactly when at least one flag is set.
- R7: A cycle with `flag_clr_we` high clears every flag whose bit in `flag_clr_data` is one. Flags whose bit is zero are unchanged.
- R8: If a flag-setting capture and a clear of the same flag fall in the same cycle, the flag ends set.
- R9: After reset, all capture registers read zero and all flags are clear.
- R10: Channels act independently. Simultaneous captures on both channels each load the same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_count | input | CNT_W | Current value of the free-running timer |
| cap_pin | input | NUM_CH | Asynchronous capture pins, bit c for channel c |
| cfg_rise | input | NUM_CH | Capture on rising transition, per channel |
| cfg_fall | input | NUM_CH | Capture on falling transition, per channel |
| cfg_irq | input | NUM_CH | Set flag on capture, per channel |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_data | input | NUM_CH | Write-one-to-clear mask for the flags |
| cap_value | output | NUM_CH*CNT_W | Capture registers; channel c in bits [c*CNT_W +: CNT_W] |
| cap_flags | output | NUM_CH | Sticky capture flags |
| irq | output | 1 | OR of all flags |

## Verification
Two functions can act in the same cycle: a capture that sets a flag, and a software clear of that flag. The bench provokes this by raising the clear strobe in exactly the cycle that the third clock edge after a pin change samples. It then judges that the flag and `irq` remain high while the register still loads. A second collision drives both pins on the same clock and expects both registers to hold the identical count.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic irq_en;
  } ecu_cfg_t;
endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ecu_edge.sv
module ecu_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign rise = level & ~level_d;
  assign fall = ~level & level_d;
endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
  import ecu_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  ecu_cfg_t         cfg,
  input  logic [CNT_W-1:0] count,
  input  logic             clr,
  output logic [CNT_W-1:0] cap,
  output logic             flag
);
  logic evt;
  logic set_flag;

  assign evt      = (rise & cfg.on_rise) | (fall & cfg.on_fall);
  assign set_flag = evt & cfg.irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n)   cap <= '0;
    else if (evt) cap <= count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_flag) flag <= 1'b1;
    else if (clr)      flag <= 1'b0;
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cap == $past(count));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cap));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_flag |=> flag);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_flag) |=> !flag);
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set_flag) |=> !flag);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        tmr_count,
  input  logic [NUM_CH-1:0]       cap_pin,
  input  logic [NUM_CH-1:0]       cfg_rise,
  input  logic [NUM_CH-1:0]       cfg_fall,
  input  logic [NUM_CH-1:0]       cfg_irq,
  input  logic                    flag_clr_we,
  input  logic [NUM_CH-1:0]       flag_clr_data,
  output logic [NUM_CH*CNT_W-1:0] cap_value,
  output logic [NUM_CH-1:0]       cap_flags,
  output logic                    irq
);
  localparam int VAL_W = NUM_CH * CNT_W;

  logic [NUM_CH-1:0] pin_s, rise_v, fall_v;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ecu_cfg_t cfg_c;
    assign cfg_c = '{on_rise: cfg_rise[c], on_fall: cfg_fall[c], irq_en: cfg_irq[c]};

    ecu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_pin[c]), .dout(pin_s[c]));

    ecu_edge u_edge (
      .clk(clk), .rst_n(rst_n), .level(pin_s[c]),
      .rise(rise_v[c]), .fall(fall_v[c]));

    ecu_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .rise(rise_v[c]), .fall(fall_v[c]),
      .cfg(cfg_c), .count(tmr_count),
      .clr(flag_clr_we & flag_clr_data[c]),
      .cap(cap_value[c*CNT_W +: CNT_W]), .flag(cap_flags[c]));
  end

  assign irq = |cap_flags;

  assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (cap_flags != '0));
  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> (cap_value == {VAL_W{1'b0}}) && (cap_flags == '0));
endmodule

// File: tb/edge_capture_unit_tb.sv
`timescale 1ns/1ps
module edge_capture_unit_tb;
  localparam int NCH = 2;
  localparam int CW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cnt = 32'h1000;
  logic [NCH-1:0] pin = '0, crise = '0, cfall = '0, cirq = '0, clr_data = '0;
  logic clr_we = 1'b0;
  logic [NCH*CW-1:0] capv;
  logic [NCH-1:0] flags;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;
  always @(negedge clk) cnt = cnt + 32'd3;

  edge_capture_unit #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_count(cnt), .cap_pin(pin),
    .cfg_rise(crise), .cfg_fall(cfall), .cfg_irq(cirq),
    .flag_clr_we(clr_we), .flag_clr_data(clr_data),
    .cap_value(capv), .cap_flags(flags), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cap_of(input int ch);
    return capv[ch*CW +: CW];
  endfunction

  // Drive pins to new value; optionally pulse clear in the capture cycle.
  task automatic drive(input logic [NCH-1:0] v, input logic clr_now,
                       input logic [NCH-1:0] cmask, output logic [CW-1:0] exp);
    @(negedge clk); #1 pin = v;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1 exp = cnt;
    if (clr_now) begin clr_we = 1'b1; clr_data = cmask; end
    @(negedge clk); #1 clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic clear(input logic [NCH-1:0] m);
    @(negedge clk); #1 clr_we = 1'b1; clr_data = m;
    @(negedge clk); #1 clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic t_reset();
    chk("R9 cap0", cap_of(0), 0); chk("R9 cap1", cap_of(1), 0);
    chk("R9 flags", flags, 0); chk("R6 irq idle", irq, 0);
  endtask

  task automatic t_rise();
    logic [CW-1:0] e;
    crise = 2'b01; cfall = 2'b00; cirq = 2'b01;
    drive(2'b01, 1'b0, '0, e);
    chk("R1 rise value", cap_of(0), e);
    chk("R5 flag set", flags, 2'b01); chk("R6 irq", irq, 1);
    clear(2'b01);
    chk("R7 cleared", flags, 0); chk("R6 irq low", irq, 0);
  endtask

  task automatic t_fall();
    logic [CW-1:0] e, keep;
    crise = 2'b00; cfall = 2'b01; cirq = 2'b00;
    drive(2'b00, 1'b0, '0, e);
    chk("R2 fall value", cap_of(0), e);
    keep = e;
    drive(2'b01, 1'b0, '0, e);
    chk("R2 rise not selected", cap_of(0), keep);
  endtask

  task automatic t_both();
    logic [CW-1:0] e;
    crise = 2'b10; cfall = 2'b10; cirq = 2'b00;
    drive(2'b11, 1'b0, '0, e);
    chk("R3 rise edge", cap_of(1), e);
    drive(2'b01, 1'b0, '0, e);
    chk("R3 fall edge", cap_of(1), e);
  endtask

  task automatic t_none();
    logic [CW-1:0] keep, e;
    keep = cap_of(1);
    crise = 2'b00; cfall = 2'b00; cirq = 2'b10;
    drive(2'b11, 1'b0, '0, e);
    chk("R4 no load rise", cap_of(1), keep);
    drive(2'b01, 1'b0, '0, e);
    chk("R4 no load fall", cap_of(1), keep);
    chk("R4 no flag", flags, 0);
  endtask

  task automatic t_noirq();
    logic [CW-1:0] e;
    crise = 2'b01; cfall = 2'b00; cirq = 2'b00;
    drive(2'b00, 1'b0, '0, e);
    drive(2'b01, 1'b0, '0, e);
    chk("R5 loads without irq", cap_of(0), e);
    chk("R5 flag stays clear", flags, 0); chk("R6 irq stays low", irq, 0);
  endtask

  task automatic t_w1c();
    logic [CW-1:0] e;
    crise = 2'b11; cfall = 2'b00; cirq = 2'b11;
    drive(2'b00, 1'b0, '0, e);
    drive(2'b11, 1'b0, '0, e);
    chk("R10 same count ch0", cap_of(0), e);
    chk("R10 same count ch1", cap_of(1), e);
    chk("R5 both flags", flags, 2'b11);
    clear(2'b00);
    chk("R7 zero mask no effect", flags, 2'b11);
    clear(2'b01);
    chk("R7 partial clear", flags, 2'b10); chk("R6 irq one flag", irq, 1);
    clear(2'b10);
    chk("R7 all clear", flags, 0);
  endtask

  task automatic t_setwins();
    logic [CW-1:0] e;
    crise = 2'b01; cfall = 2'b00; cirq = 2'b01;
    drive(2'b00, 1'b0, '0, e);
    drive(2'b01, 1'b1, 2'b01, e);
    chk("R8 set beats clear", flags, 2'b01);
    chk("R8 irq held", irq, 1);
    chk("R8 value loaded", cap_of(0), e);
    clear(2'b01);
    chk("R7 later clear", flags, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_none();
    t_noirq();
    t_w1c();
    t_setwins();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule